// File: doc/BRIEF.md
# Timer Interrupt Router with Status and Message Delivery

This block sits behind a bank of timer comparators. Each cycle it takes one match pulse per channel and turns it into an interrupt. It does this in one of three ways: a held level on an interrupt line with a status bit, a one-cycle pulse on a line, or a posted 32-bit message write. Each channel has its own configuration inputs. These select enable, level or edge signalling, the target line, and message delivery. Software clears level-mode interrupts by writing ones to the status vector.

A global legacy-replacement mode takes over two fixed lines, line 0 and line 8, for channels 0 and 1. While this mode is on, the block blocks the external periodic-timer and real-time-clock interrupt inputs, and it drives a gate output low so that the external periodic timer stops. The block samples the real-time-clock input level on every cycle. When legacy mode ends, line 8 therefore shows the current level of that input again.

Every output is set by registers that update on one clock edge. An input change at edge k shows at the outputs right after edge k.

Top module: `irq_route_status`

## Requirements
- R1: After a synchronous active-low reset, the status vector is zero, all interrupt lines are low, the message valid is low and the periodic-timer gate output is high.
- R2: A match on an enabled channel in level mode (level bit 1) with message delivery off sets that channel's status bit. The bit holds the channel's target line high until the bit is cleared.
- R3: A match on an enabled channel in edge mode (level bit 0) with message delivery off clears the status bit. It also pulses the target line high for exactly one cycle.
- R4: A status write with a 1 in bit i clears status bit i and drops its line. A 0 in bit i changes nothing. If a match and a 1-write reach the same channel in the same cycle, the match wins.
- R5: When a channel's enable or the global enable is low, that channel's status bit is cleared, its line request is dropped and any message it has waiting is discarded.
- R6: A match on an enabled channel with message delivery on produces a message with valid high. The message carries that channel's message address and data inputs. No line is driven and the status bit is left unchanged.
- R7: Messages from several channels are queued. One message is issued per cycle, lowest channel index first.
- R8: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8. Every other channel, and every channel outside legacy mode, drives the line given by its RW-bit route field.
- R9: The gate output is low in legacy mode and high outside it. Outside legacy mode, line 0 also carries the sampled external periodic-timer input and line 8 carries the sampled real-time-clock input. In legacy mode both inputs are blocked, but the real-time-clock level is still sampled, so line 8 shows its current level again as soon as legacy mode ends.
- R10: A 0-to-1 change of a channel's message-enable bit clears that channel's status bit and so lowers its line.
- R11: A line shared by several channels is the OR of their level requests, their edge pulses and any legacy pass-through input.
- R12: Every output reflects the inputs present at a clock edge immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| match_i | input | NCH | One-cycle match pulse per channel |
| ch_en_i | input | NCH | Per-channel enable |
| ch_level_i | input | NCH | 1 = level signalling, 0 = edge |
| ch_msg_en_i | input | NCH | Per-channel message delivery enable |
| ch_route_i | input | NCH*RW | Target line per channel, channel i in bits [i*RW +: RW] |
| ch_msg_addr_i | input | NCH*MSG_W | Message address per channel |
| ch_msg_data_i | input | NCH*MSG_W | Message data per channel |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy replacement mode |
| ext_pit_i | input | 1 | External periodic-timer interrupt level |
| ext_rtc_i | input | 1 | External real-time-clock interrupt level |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NCH | Status write data (1 clears) |
| irq_o | output | NLINES | Interrupt lines |
| pit_gate_o | output | 1 | High lets the external periodic timer run |
| status_o | output | NCH | Status vector |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | MSG_W | Message address |
| msg_data_o | output | MSG_W | Message data |

## Verification
The bench attacks the points where line sources overlap. It clears a level request on a line in the same cycle that an edge pulse hits that line, and it enters and leaves legacy mode while the real-time-clock input moves underneath. A wrong OR would drop the pulse, and a design that stops sampling during legacy mode would bring back a stale line 8. It also issues two simultaneous messages to catch a queue that loses one or swaps their order, and raises message-enable on a channel whose status bit is set to catch a line that stays stuck high. A cycle-accurate model compares every output on every clock, so an extra register stage or a lost one-cycle pulse shows up at once.

// File: rtl/irq_rs_pkg.sv
package irq_rs_pkg;

    typedef struct packed {
        logic sts;
        logic pulse;
        logic men_prev;
    } chan_st_t;

    typedef struct packed {
        logic legacy;
        logic rtc;
        logic pit;
    } glob_st_t;

endpackage

// File: rtl/irq_rs_chan.sv
module irq_rs_chan
    import irq_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic en_i,
    input  logic level_i,
    input  logic msg_en_i,
    input  logic clr_i,
    output logic sts_o,
    output logic pulse_o,
    output logic msg_req_o
);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pulse    = 1'b0;
        st_d.men_prev = msg_en_i;
        if (!en_i) begin
            st_d.sts = 1'b0;
        end else if (match_i && !msg_en_i) begin
            st_d.sts   = level_i;
            st_d.pulse = !level_i;
        end else if (clr_i) begin
            st_d.sts = 1'b0;
        end else if (msg_en_i && !st_q.men_prev) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o     = st_q.sts;
    assign pulse_o   = st_q.pulse;
    assign msg_req_o = en_i & match_i & msg_en_i;

endmodule

// File: rtl/irq_rs_msg_arb.sv
module irq_rs_msg_arb #(
    parameter int NCH   = 4,
    parameter int MSG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       req_i,
    input  logic [NCH-1:0]       keep_i,
    input  logic [NCH*MSG_W-1:0] addr_i,
    input  logic [NCH*MSG_W-1:0] data_i,
    output logic                 valid_o,
    output logic [MSG_W-1:0]     addr_o,
    output logic [MSG_W-1:0]     data_o
);

    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [NCH-1:0]   pend;
        logic             vld;
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } arb_st_t;

    arb_st_t        st_d, st_q;
    logic [NCH-1:0] cand;
    logic [SW-1:0]  sel;

    always_comb begin
        cand = (st_q.pend | req_i) & keep_i;
        sel  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) sel = SW'(i);
        end
        st_d      = st_q;
        st_d.vld  = |cand;
        st_d.pend = cand;
        if (|cand) begin
            st_d.pend[sel] = 1'b0;
            st_d.addr      = addr_i[sel*MSG_W +: MSG_W];
            st_d.data      = data_i[sel*MSG_W +: MSG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;

endmodule

// File: rtl/irq_rs_line_mux.sv
module irq_rs_line_mux #(
    parameter int NCH    = 4,
    parameter int NLINES = 16,
    parameter int LEG_A  = 0,
    parameter int LEG_B  = 8,
    localparam int RW    = $clog2(NLINES)
) (
    input  logic [NCH-1:0]    req_i,
    input  logic [NCH*RW-1:0] route_i,
    input  logic              legacy_i,
    input  logic              pit_i,
    input  logic              rtc_i,
    output logic [NLINES-1:0] lines_o
);

    logic [RW-1:0] tgt;

    always_comb begin
        lines_o = '0;
        tgt     = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            tgt = route_i[ch*RW +: RW];
            if (legacy_i && ch == 0) tgt = RW'(LEG_A);
            if (legacy_i && ch == 1) tgt = RW'(LEG_B);
            lines_o[tgt] = lines_o[tgt] | req_i[ch];
        end
        if (!legacy_i) begin
            lines_o[LEG_A] = lines_o[LEG_A] | pit_i;
            lines_o[LEG_B] = lines_o[LEG_B] | rtc_i;
        end
    end

endmodule

// File: rtl/irq_route_status.sv
module irq_route_status
    import irq_rs_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NLINES = 16,
    parameter int MSG_W  = 32,
    parameter int LEG_A  = 0,
    parameter int LEG_B  = 8,
    localparam int RW    = $clog2(NLINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       match_i,
    input  logic [NCH-1:0]       ch_en_i,
    input  logic [NCH-1:0]       ch_level_i,
    input  logic [NCH-1:0]       ch_msg_en_i,
    input  logic [NCH*RW-1:0]    ch_route_i,
    input  logic [NCH*MSG_W-1:0] ch_msg_addr_i,
    input  logic [NCH*MSG_W-1:0] ch_msg_data_i,
    input  logic                 glb_en_i,
    input  logic                 legacy_i,
    input  logic                 ext_pit_i,
    input  logic                 ext_rtc_i,
    input  logic                 sts_wr_i,
    input  logic [NCH-1:0]       sts_wdata_i,
    output logic [NLINES-1:0]    irq_o,
    output logic                 pit_gate_o,
    output logic [NCH-1:0]       status_o,
    output logic                 msg_valid_o,
    output logic [MSG_W-1:0]     msg_addr_o,
    output logic [MSG_W-1:0]     msg_data_o
);

    glob_st_t       g_d, g_q;
    logic [NCH-1:0] ch_live;
    logic [NCH-1:0] pulse;
    logic [NCH-1:0] msg_req;
    logic [NCH-1:0] line_req;

    always_comb begin
        g_d        = g_q;
        g_d.legacy = legacy_i;
        g_d.rtc    = ext_rtc_i;
        g_d.pit    = ext_pit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign ch_live = ch_en_i & {NCH{glb_en_i}};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        irq_rs_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .match_i  (match_i[i]),
            .en_i     (ch_live[i]),
            .level_i  (ch_level_i[i]),
            .msg_en_i (ch_msg_en_i[i]),
            .clr_i    (sts_wr_i & sts_wdata_i[i]),
            .sts_o    (status_o[i]),
            .pulse_o  (pulse[i]),
            .msg_req_o(msg_req[i])
        );
    end

    assign line_req = status_o | pulse;

    irq_rs_line_mux #(
        .NCH   (NCH),
        .NLINES(NLINES),
        .LEG_A (LEG_A),
        .LEG_B (LEG_B)
    ) u_mux (
        .req_i   (line_req),
        .route_i (ch_route_i),
        .legacy_i(g_q.legacy),
        .pit_i   (g_q.pit),
        .rtc_i   (g_q.rtc),
        .lines_o (irq_o)
    );

    irq_rs_msg_arb #(
        .NCH  (NCH),
        .MSG_W(MSG_W)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (msg_req),
        .keep_i (ch_live),
        .addr_i (ch_msg_addr_i),
        .data_i (ch_msg_data_i),
        .valid_o(msg_valid_o),
        .addr_o (msg_addr_o),
        .data_o (msg_data_o)
    );

    assign pit_gate_o = !g_q.legacy;

endmodule

// File: rtl/irq_rs_chk.sv
module irq_rs_chk #(
    parameter int NCH    = 4,
    parameter int NLINES = 16,
    parameter int LEG_B  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    match_i,
    input logic [NCH-1:0]    ch_en_i,
    input logic [NCH-1:0]    ch_level_i,
    input logic [NCH-1:0]    ch_msg_en_i,
    input logic              glb_en_i,
    input logic              legacy_i,
    input logic              ext_rtc_i,
    input logic              sts_wr_i,
    input logic [NCH-1:0]    sts_wdata_i,
    input logic [NLINES-1:0] irq_o,
    input logic              pit_gate_o,
    input logic [NCH-1:0]    status_o,
    input logic              msg_valid_o
);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
            glb_en_i && ch_en_i[i] && match_i[i] && ch_level_i[i] && !ch_msg_en_i[i]
            |=> status_o[i]);
        a_r3_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
            glb_en_i && ch_en_i[i] && match_i[i] && !ch_level_i[i] && !ch_msg_en_i[i]
            |=> !status_o[i]);
        a_r4_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr_i && sts_wdata_i[i] && !match_i[i] |=> !status_o[i]);
        a_r6_msg_issued: assert property (@(posedge clk) disable iff (!rst_n)
            glb_en_i && ch_en_i[i] && match_i[i] && ch_msg_en_i[i] |=> msg_valid_o);
    end

    a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> (status_o == '0) && !msg_valid_o);
    a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !pit_gate_o);
    a_r9_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> pit_gate_o);
    a_r9_rtc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i && ext_rtc_i |=> irq_o[LEG_B]);

endmodule

bind irq_route_status irq_rs_chk #(
    .NCH   (NCH),
    .NLINES(NLINES),
    .LEG_B (LEG_B)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match_i),
    .ch_en_i    (ch_en_i),
    .ch_level_i (ch_level_i),
    .ch_msg_en_i(ch_msg_en_i),
    .glb_en_i   (glb_en_i),
    .legacy_i   (legacy_i),
    .ext_rtc_i  (ext_rtc_i),
    .sts_wr_i   (sts_wr_i),
    .sts_wdata_i(sts_wdata_i),
    .irq_o      (irq_o),
    .pit_gate_o (pit_gate_o),
    .status_o   (status_o),
    .msg_valid_o(msg_valid_o)
);

// File: tb/irq_route_status_test.sv
module irq_route_status_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NL  = 16;
    localparam int RW  = 4;
    localparam int MW  = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic [NCH-1:0] match_i = '0, ch_en_i = '0, ch_level_i = '0, ch_msg_en_i = '0;
    logic [NCH*RW-1:0] ch_route_i;
    logic [NCH*MW-1:0] ch_msg_addr_i, ch_msg_data_i;
    logic glb_en_i = 0, legacy_i = 0, ext_pit_i = 0, ext_rtc_i = 0, sts_wr_i = 0;
    logic [NCH-1:0] sts_wdata_i = '0;
    logic [NL-1:0] irq_o;
    logic pit_gate_o, msg_valid_o;
    logic [NCH-1:0] status_o;
    logic [MW-1:0] msg_addr_o, msg_data_o;

    // routes: ch0->3, ch1->5, ch2->5, ch3->10
    assign ch_route_i = {4'd10, 4'd5, 4'd5, 4'd3};
    assign ch_msg_addr_i = {32'hA300_0000, 32'hA200_0000, 32'hA100_0000, 32'hA000_0000};
    assign ch_msg_data_i = {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000};

    irq_route_status uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // behavioural reference model
    bit m_sts[NCH], m_pulse[NCH], m_prev[NCH], m_pend[NCH];
    bit m_vld, m_leg, m_rtc, m_pit;
    logic [MW-1:0] m_addr = '0, m_data = '0;
    int route_tbl[NCH] = '{3, 5, 5, 10};

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_sts[i]) begin
                m_sts[i] = 0; m_pulse[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
            end
            m_vld = 0; m_leg = 0; m_rtc = 0; m_pit = 0;
            m_addr = '0; m_data = '0;
        end else begin
            int pick;
            pick = -1;
            for (int i = 0; i < NCH; i++) begin
                bit live;
                live = ch_en_i[i] && glb_en_i;
                m_pulse[i] = 0;
                if (!live) m_sts[i] = 0;
                else if (match_i[i] && !ch_msg_en_i[i]) begin
                    m_sts[i] = ch_level_i[i];
                    m_pulse[i] = !ch_level_i[i];
                end else if (sts_wr_i && sts_wdata_i[i]) m_sts[i] = 0;
                else if (ch_msg_en_i[i] && !m_prev[i]) m_sts[i] = 0;
                m_prev[i] = ch_msg_en_i[i];
                if (!live) m_pend[i] = 0;
                else if (match_i[i] && ch_msg_en_i[i]) m_pend[i] = 1;
                if (m_pend[i] && pick < 0) pick = i;
            end
            m_vld = (pick >= 0);
            if (pick >= 0) begin
                m_pend[pick] = 0;
                m_addr = ch_msg_addr_i[pick*MW +: MW];
                m_data = ch_msg_data_i[pick*MW +: MW];
            end
            m_leg = legacy_i; m_rtc = ext_rtc_i; m_pit = ext_pit_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NL-1:0] e_irq;
            logic [NCH-1:0] e_sts;
            e_irq = '0;
            for (int i = 0; i < NCH; i++) begin
                int t;
                t = route_tbl[i];
                if (m_leg && i == 0) t = 0;
                if (m_leg && i == 1) t = 8;
                if (m_sts[i] || m_pulse[i]) e_irq[t] = 1'b1;
                e_sts[i] = m_sts[i];
            end
            if (!m_leg) begin
                if (m_pit) e_irq[0] = 1'b1;
                if (m_rtc) e_irq[8] = 1'b1;
            end
            chk(irq_o === e_irq, "R12 model irq_o", 64'(irq_o), 64'(e_irq));
            chk(status_o === e_sts, "R12 model status_o", 64'(status_o), 64'(e_sts));
            chk(pit_gate_o === !m_leg, "R12 model pit_gate_o", 64'(pit_gate_o), 64'(!m_leg));
            chk(msg_valid_o === m_vld, "R12 model msg_valid_o", 64'(msg_valid_o), 64'(m_vld));
            if (m_vld) begin
                chk(msg_addr_o === m_addr, "R12 model msg_addr_o", 64'(msg_addr_o), 64'(m_addr));
                chk(msg_data_o === m_data, "R12 model msg_data_o", 64'(msg_data_o), 64'(m_data));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk(status_o == 0, "R1 status", 64'(status_o), 0);
        chk(irq_o == 0, "R1 irq", 64'(irq_o), 0);
        chk(pit_gate_o == 1, "R1 gate", 64'(pit_gate_o), 1);
        chk(msg_valid_o == 0, "R1 msg", 64'(msg_valid_o), 0);

        // R2 level
        glb_en_i = 1; ch_en_i = 4'hF; ch_level_i = 4'b0001;
        match_i = 4'b0001; step(1); match_i = 0;
        chk(status_o[0] == 1, "R2 status set", 64'(status_o), 1);
        chk(irq_o[3] == 1, "R2 line high", 64'(irq_o), 64'h8);
        step(3);
        chk(irq_o[3] == 1, "R2 line held", 64'(irq_o), 64'h8);

        // R4 write 0 then write 1
        sts_wr_i = 1; sts_wdata_i = 4'b0000; step(1);
        chk(status_o[0] == 1, "R4 write0 no effect", 64'(status_o), 1);
        sts_wdata_i = 4'b0001; step(1); sts_wr_i = 0; sts_wdata_i = 0;
        chk(status_o[0] == 0, "R4 write1 clears", 64'(status_o), 0);
        chk(irq_o[3] == 0, "R4 line drops", 64'(irq_o), 0);

        // R3 edge on ch2
        match_i = 4'b0100; step(1); match_i = 0;
        chk(irq_o[5] == 1 && status_o[2] == 0, "R3 pulse", 64'(irq_o), 64'h20);
        step(1);
        chk(irq_o[5] == 0, "R3 pulse one cycle", 64'(irq_o), 0);

        // R11 shared line 5: ch1 level, ch2 edge
        ch_level_i = 4'b0011;
        match_i = 4'b0010; step(1); match_i = 0;
        chk(irq_o[5] == 1, "R11 level on shared", 64'(irq_o), 64'h20);
        sts_wr_i = 1; sts_wdata_i = 4'b0010; match_i = 4'b0100; step(1);
        sts_wr_i = 0; sts_wdata_i = 0; match_i = 0;
        chk(irq_o[5] == 1 && status_o[1] == 0, "R11 pulse ORed during clear", 64'(irq_o), 64'h20);
        step(1);
        chk(irq_o[5] == 0, "R11 line low", 64'(irq_o), 0);

        // R4 match wins over same-cycle clear
        match_i = 4'b0001; sts_wr_i = 1; sts_wdata_i = 4'b0001; step(1);
        match_i = 0; sts_wr_i = 0; sts_wdata_i = 0;
        chk(status_o[0] == 1, "R4 match wins", 64'(status_o), 1);

        // R5 channel disable, then global disable
        ch_en_i = 4'b1110; step(1);
        chk(status_o[0] == 0 && irq_o[3] == 0, "R5 channel off", 64'(status_o), 0);
        ch_en_i = 4'hF; match_i = 4'b0001; step(1); match_i = 0;
        glb_en_i = 0; step(1);
        chk(status_o == 0 && irq_o == 0, "R5 global off", 64'(irq_o), 0);
        glb_en_i = 1;

        // R6 message on ch3
        ch_msg_en_i = 4'b1000; step(1);
        match_i = 4'b1000; step(1); match_i = 0;
        chk(msg_valid_o == 1, "R6 valid", 64'(msg_valid_o), 1);
        chk(msg_addr_o == 32'hA300_0000, "R6 addr", 64'(msg_addr_o), 64'hA300_0000);
        chk(msg_data_o == 32'hD000_0003, "R6 data", 64'(msg_data_o), 64'hD000_0003);
        chk(irq_o[10] == 0 && status_o[3] == 0, "R6 no line", 64'(irq_o), 0);
        step(1);
        chk(msg_valid_o == 0, "R6 single", 64'(msg_valid_o), 0);

        // R7 two simultaneous messages
        ch_msg_en_i = 4'b1011; match_i = 4'b0011; step(1); match_i = 0;
        chk(msg_valid_o && msg_addr_o == 32'hA000_0000, "R7 first ch0", 64'(msg_addr_o), 64'hA000_0000);
        step(1);
        chk(msg_valid_o && msg_addr_o == 32'hA100_0000, "R7 second ch1", 64'(msg_addr_o), 64'hA100_0000);
        step(1);
        chk(msg_valid_o == 0, "R7 drained", 64'(msg_valid_o), 0);

        // R10 message-enable rise clears status
        ch_level_i = 4'b0111; match_i = 4'b0100; step(1); match_i = 0;
        chk(status_o[2] == 1, "R10 prep", 64'(status_o), 4);
        ch_msg_en_i = 4'b1111; step(1);
        chk(status_o[2] == 0 && irq_o[5] == 0, "R10 cleared", 64'(status_o), 0);

        // R9 pass-through, R8 legacy routing
        ch_msg_en_i = 0; ext_rtc_i = 1; ext_pit_i = 1; step(1);
        chk(irq_o[8] == 1 && irq_o[0] == 1, "R9 pass-through", 64'(irq_o), 64'h101);
        legacy_i = 1; step(1);
        chk(pit_gate_o == 0 && irq_o[0] == 0 && irq_o[8] == 0, "R9 legacy gates", 64'(irq_o), 0);
        match_i = 4'b0011; step(1); match_i = 0;
        chk(irq_o[0] == 1 && irq_o[8] == 1 && irq_o[3] == 0, "R8 legacy routes", 64'(irq_o), 64'h101);
        sts_wr_i = 1; sts_wdata_i = 4'b0011; step(1); sts_wr_i = 0; sts_wdata_i = 0;
        chk(irq_o == 0, "R8 cleared in legacy", 64'(irq_o), 0);
        ext_rtc_i = 0; step(1);
        ext_rtc_i = 1; step(1);
        legacy_i = 0; step(1);
        chk(pit_gate_o == 1 && irq_o[8] == 1 && irq_o[0] == 1, "R9 restore on exit", 64'(irq_o), 64'h101);
        ext_pit_i = 0; ext_rtc_i = 0; step(1);
        chk(irq_o == 0, "R9 inputs low", 64'(irq_o), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule